// File: doc/BRIEF.md
# Bus-Mapped Control Register Block with Hardware Update Ports

This block is a pipelined single-transfer bus slave (AHB-Lite protocol) that holds a small bank of 16-bit control fields. Software reaches the fields through the bus with byte, halfword or word reads and writes. Surrounding hardware can load any field directly through a data input and a per-field load enable. Every field's current value is also driven continuously on an output port, so logic nearby can use the settings without going through the bus.

The default configuration has two 32-bit registers, each split into two 16-bit fields, for a decoded window of 8 bytes. Valid transfers complete with no wait states. Any transfer that addresses a location past the window gets the two-cycle ERROR response, and the stored state is left as it was.

Top module: `ahb_reg_slave`

## Requirements
- R1: Field k occupies bus bytes 2k and 2k+1 (field 0 at offset 0, field 1 at 2, field 2 at 4, field 3 at 6). Byte lanes are little-endian: the byte at address a travels on HWDATA/HRDATA bits [8*(a mod 4)+7 : 8*(a mod 4)]. Field k is driven on fieldQ[16k+15:16k].
- R2: Transfers of size HSIZE=0 (byte), 1 (halfword) and 2 (word) are supported for reads and writes. A read returns the whole addressed 32-bit word on HRDATA, so the addressed lanes hold the last value written there.
- R3: A bus write updates only the bytes it addresses. Every other byte of every field keeps its value.
- R4: An address phase is taken when HSEL is high, HTRANS is NONSEQ (2) or SEQ (3) and HREADY is high. IDLE (0) and BUSY (1) transfers have no effect. Write data is taken from HWDATA in the cycle that follows the address phase.
- R5: A transfer to address 8 or above gets ERROR. In the first response cycle HREADYOUT=0 and HRESP=1. In the second cycle HREADYOUT=1 and HRESP=1. After that the slave returns to OKAY.
- R6: A write that receives ERROR changes no field.
- R7: Valid transfers complete in their data phase with HREADYOUT=1 and HRESP=0.
- R8: When hwFieldWe[k] is high at a clock edge, field k loads hwFieldData[16k+15:16k]. The new value is visible on fieldQ, and to later bus reads, after that edge.
- R9: When hwFieldWe[k] is low, hwFieldData for field k is ignored.
- R10: If a hardware load and a bus write hit the same field at the same edge, the hardware value is stored in that field. The bus write still updates the other fields it addresses.
- R11: A synchronous reset (rstN low at a clock edge) clears every field to zero and leaves the slave ready with an OKAY response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| hsel | input | 1 | Slave select |
| haddr | input | ADDR_W | Byte address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | High for a write |
| hsize | input | 3 | Transfer size |
| hwdata | input | 32 | Write data (data phase) |
| hready | input | 1 | Bus ready, taken from the selected slave's response |
| hreadyout | output | 1 | Slave ready |
| hresp | output | 1 | 0 = OKAY, 1 = ERROR |
| hrdata | output | 32 | Read data |
| hwFieldData | input | NUM_REGS*2*FIELD_W | Hardware load values, field k in slice k |
| hwFieldWe | input | NUM_REGS*2 | Hardware load enable per field |
| fieldQ | output | NUM_REGS*2*FIELD_W | Current field values |

## Verification
The bench writes every aligned address at every size, putting a distinct full 32-bit word on HWDATA each time, and reads every register back after each write. The unaddressed lanes carry data that must be ignored, so a wrong lane mask or a wrong field placement shows up as a wrong byte. Out-of-window addresses are tried for reads and writes, and the two response cycles are checked one at a time, which separates an error response that is too short from one that lets a write through. Hardware loads are applied to alternating fields, with the enable low and the data changing, and at the same edge as a bus write to a shared word. These patterns separate the field that was loaded from the fields that must be held, and separate hardware priority from bus priority.

// File: rtl/ahb_reg_pkg.sv
package ahb_reg_pkg;

  localparam int BUS_W     = 32;
  localparam int BUS_BYTES = BUS_W / 8;
  localparam int IDX_W     = 16;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } transKind_t;

  typedef enum logic [2:0] {
    SZ_BYTE = 3'd0,
    SZ_HALF = 3'd1,
    SZ_WORD = 3'd2
  } sizeKind_t;

  // control -> datapath strobes for the current data phase
  typedef struct packed {
    logic                 wrEn;
    logic [BUS_BYTES-1:0] byteEn;
    logic [IDX_W-1:0]     wordIdx;
  } dpStrobe_t;

endpackage

// File: rtl/ahbRegCtrl.sv
module ahbRegCtrl
  import ahb_reg_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_WORDS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hsel,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic [2:0]        hsize,
  input  logic              hready,
  output logic              hreadyout,
  output logic              hresp,
  output dpStrobe_t         strobes
);

  localparam int WINDOW_BYTES = NUM_WORDS * BUS_BYTES;

  typedef enum logic [1:0] {ST_OKAY, ST_ERR1, ST_ERR2} respState_t;

  respState_t respState;
  logic       addrPhase;
  logic       inWindow;
  logic       dpWrite;
  logic [1:0] dpLow;
  logic [2:0] dpSize;
  logic [IDX_W-1:0] dpWord;
  logic [BUS_BYTES-1:0] laneMask;

  assign addrPhase = hsel && hready &&
                     (htrans == TR_NONSEQ || htrans == TR_SEQ);
  assign inWindow  = (haddr < ADDR_W'(WINDOW_BYTES));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respState <= ST_OKAY;
      dpWrite   <= 1'b0;
      dpLow     <= '0;
      dpSize    <= '0;
      dpWord    <= '0;
    end else begin
      case (respState)
        ST_ERR1: respState <= ST_ERR2;
        default: respState <= (addrPhase && !inWindow) ? ST_ERR1 : ST_OKAY;
      endcase
      dpWrite <= addrPhase && inWindow && hwrite;
      if (addrPhase) begin
        dpLow  <= haddr[1:0];
        dpSize <= hsize;
        dpWord <= IDX_W'(haddr >> 2);
      end
    end
  end

  always_comb begin
    case (dpSize)
      SZ_BYTE: laneMask = 4'b0001 << dpLow;
      SZ_HALF: laneMask = 4'b0011 << {dpLow[1], 1'b0};
      default: laneMask = 4'b1111;
    endcase
  end

  assign hreadyout       = (respState != ST_ERR1);
  assign hresp           = (respState != ST_OKAY);
  assign strobes.wrEn    = dpWrite;
  assign strobes.byteEn  = laneMask;
  assign strobes.wordIdx = dpWord;

  // R5: out-of-window address phase opens the first error cycle
  a_r5_err_entry: assert property (@(posedge clk) disable iff (!rstN)
    (addrPhase && !inWindow) |=> (hresp && !hreadyout));
  // R5: first error cycle is always followed by the second
  a_r5_err_second: assert property (@(posedge clk) disable iff (!rstN)
    (hresp && !hreadyout) |=> (hresp && hreadyout));
  // R6: no write strobe while an error response is in progress
  a_r6_err_no_write: assert property (@(posedge clk) disable iff (!rstN)
    hresp |-> !strobes.wrEn);
  // R7: an OKAY response is never stretched
  a_r7_okay_ready: assert property (@(posedge clk) disable iff (!rstN)
    !hresp |-> hreadyout);

endmodule

// File: rtl/ahbRegData.sv
module ahbRegData
  import ahb_reg_pkg::*;
#(
  parameter int NUM_WORDS = 2,
  parameter int FIELD_W   = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpStrobe_t                 strobes,
  input  logic [BUS_W-1:0]          hwdata,
  input  logic [NUM_WORDS*(BUS_W/FIELD_W)*FIELD_W-1:0] hwFieldData,
  input  logic [NUM_WORDS*(BUS_W/FIELD_W)-1:0]         hwFieldWe,
  output logic [BUS_W-1:0]          hrdata,
  output logic [NUM_WORDS*(BUS_W/FIELD_W)*FIELD_W-1:0] fieldQ
);

  localparam int FPW      = BUS_W / FIELD_W;
  localparam int NF       = NUM_WORDS * FPW;
  localparam int FBYTES   = FIELD_W / 8;

  logic [FIELD_W-1:0] fieldReg [NF];
  logic [NF-1:0]      busTouch;

  for (genvar f = 0; f < NF; f++) begin : g_field
    localparam int WIDX = f / FPW;
    localparam int HOFF = f % FPW;

    logic [FBYTES-1:0]  laneEn;
    logic [FIELD_W-1:0] busNext;
    logic               wordHit;

    assign wordHit     = strobes.wrEn && (strobes.wordIdx == IDX_W'(WIDX));
    assign laneEn      = strobes.byteEn[HOFF*FBYTES +: FBYTES];
    assign busTouch[f] = wordHit && (laneEn != '0);

    always_comb begin
      for (int b = 0; b < FBYTES; b++) begin
        busNext[8*b +: 8] = (wordHit && laneEn[b])
                          ? hwdata[HOFF*FIELD_W + 8*b +: 8]
                          : fieldReg[f][8*b +: 8];
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN)
        fieldReg[f] <= '0;
      else if (hwFieldWe[f])
        fieldReg[f] <= hwFieldData[f*FIELD_W +: FIELD_W];
      else
        fieldReg[f] <= busNext;
    end

    assign fieldQ[f*FIELD_W +: FIELD_W] = fieldReg[f];

    // R8, R10: hardware load wins and lands exactly
    a_r8_hw_load: assert property (@(posedge clk) disable iff (!rstN)
      hwFieldWe[f] |=> (fieldQ[f*FIELD_W +: FIELD_W] ==
                        $past(hwFieldData[f*FIELD_W +: FIELD_W])));
    // R9, R3: untouched field keeps its value
    a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
      (!hwFieldWe[f] && !busTouch[f]) |=> $stable(fieldQ[f*FIELD_W +: FIELD_W]));
  end

  always_comb begin
    hrdata = '0;
    for (int f = 0; f < NF; f++) begin
      if (strobes.wordIdx == IDX_W'(f / FPW))
        hrdata[(f % FPW)*FIELD_W +: FIELD_W] = fieldReg[f];
    end
  end

  // R11: reset clears every field
  a_r11_reset_clear: assert property (@(posedge clk)
    !rstN |=> (fieldQ == '0));

endmodule

// File: rtl/ahb_reg_slave.sv
module ahb_reg_slave
  import ahb_reg_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NUM_REGS = 2,
  parameter int FIELD_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hsel,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic [2:0]        hsize,
  input  logic [31:0]       hwdata,
  input  logic              hready,
  output logic              hreadyout,
  output logic              hresp,
  output logic [31:0]       hrdata,
  input  logic [NUM_REGS*(32/FIELD_W)*FIELD_W-1:0] hwFieldData,
  input  logic [NUM_REGS*(32/FIELD_W)-1:0]         hwFieldWe,
  output logic [NUM_REGS*(32/FIELD_W)*FIELD_W-1:0] fieldQ
);

  dpStrobe_t strobes;

  ahbRegCtrl #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_REGS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hsel      (hsel),
    .haddr     (haddr),
    .htrans    (htrans),
    .hwrite    (hwrite),
    .hsize     (hsize),
    .hready    (hready),
    .hreadyout (hreadyout),
    .hresp     (hresp),
    .strobes   (strobes)
  );

  ahbRegData #(.NUM_WORDS(NUM_REGS), .FIELD_W(FIELD_W)) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .hwdata      (hwdata),
    .hwFieldData (hwFieldData),
    .hwFieldWe   (hwFieldWe),
    .hrdata      (hrdata),
    .fieldQ      (fieldQ)
  );

endmodule

// File: tb/ahb_reg_slave_bench.sv
module ahb_reg_slave_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        hsel;
  logic [31:0] haddr;
  logic [1:0]  htrans;
  logic        hwrite;
  logic [2:0]  hsize;
  logic [31:0] hwdata;
  logic        hready;
  logic        hreadyout;
  logic        hresp;
  logic [31:0] hrdata;
  logic [63:0] hwFieldData;
  logic [3:0]  hwFieldWe;
  logic [63:0] fieldQ;

  int testCount = 0;
  int failCount = 0;
  bit finished  = 0;

  logic [15:0] model [4];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign hready = hreadyout;

  ahb_reg_slave u_ahb_reg_slave (
    .clk(clk), .rstN(rstN), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata), .hready(hready),
    .hreadyout(hreadyout), .hresp(hresp), .hrdata(hrdata),
    .hwFieldData(hwFieldData), .hwFieldWe(hwFieldWe), .fieldQ(fieldQ)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] modelFlat();
    return {model[3], model[2], model[1], model[0]};
  endfunction

  function automatic logic [31:0] modelWord(input int w);
    return {model[2*w+1], model[2*w]};
  endfunction

  function automatic logic [31:0] sizeMask(input int a, input int sz);
    logic [31:0] m = '0;
    for (int i = 0; i < (1 << sz); i++) m[8*((a % 4) + i) +: 8] = 8'hFF;
    return m;
  endfunction

  function automatic void applyWrite(input int a, input int sz, input logic [31:0] wd);
    for (int i = 0; i < (1 << sz); i++) begin
      int ba = a + i;
      model[ba / 2][8*(ba % 2) +: 8] = wd[8*(ba % 4) +: 8];
    end
  endfunction

  task automatic idleBus();
    hsel = 0; htrans = 2'b00; hwrite = 0; hsize = 3'd0; haddr = '0;
  endtask

  task automatic busWrite(input int a, input int sz, input logic [31:0] wd);
    @(negedge clk);
    hsel = 1; haddr = 32'(a); htrans = 2'b10; hwrite = 1; hsize = 3'(sz);
    @(negedge clk);
    idleBus();
    hwdata = wd;
    check("R7 write ready/okay", {62'd0, hreadyout, hresp}, 64'b10);
  endtask

  task automatic busRead(input int a, input int sz, output logic [31:0] rd);
    @(negedge clk);
    hsel = 1; haddr = 32'(a); htrans = 2'b10; hwrite = 0; hsize = 3'(sz);
    @(negedge clk);
    idleBus();
    rd = hrdata;
    check("R7 read ready/okay", {62'd0, hreadyout, hresp}, 64'b10);
  endtask

  task automatic errAccess(input int a, input logic wr);
    @(negedge clk);
    hsel = 1; haddr = 32'(a); htrans = 2'b10; hwrite = wr; hsize = 3'd0;
    @(negedge clk);
    idleBus();
    hwdata = 32'hFFFF_FFFF;
    check("R5 error cycle 1", {62'd0, hreadyout, hresp}, 64'b01);
    @(negedge clk);
    check("R5 error cycle 2", {62'd0, hreadyout, hresp}, 64'b11);
    @(negedge clk);
    check("R5 back to okay", {62'd0, hreadyout, hresp}, 64'b10);
    check("R6 no change after error", fieldQ, modelFlat());
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] wd;
    int seq = 0;
    idleBus();
    hwdata = '0; hwFieldData = '0; hwFieldWe = '0; rstN = 0;
    for (int k = 0; k < 4; k++) model[k] = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R11 reset fields", fieldQ, 64'd0);
    check("R11 reset response", {62'd0, hreadyout, hresp}, 64'b10);

    // sweep all sizes and aligned addresses
    for (int sz = 0; sz < 3; sz++) begin
      for (int a = 0; a < 8; a += (1 << sz)) begin
        seq++;
        wd = (32'h9E37_79B9 * 32'(seq)) ^ 32'h5A5A_0000;
        busWrite(a, sz, wd);
        applyWrite(a, sz, wd);
        @(negedge clk);
        check("R1 R3 field outputs", fieldQ, modelFlat());
        busRead(a, sz, rd);
        check("R2 sized readback", 64'(rd & sizeMask(a, sz)),
              64'(wd & sizeMask(a, sz)));
        for (int w = 0; w < 2; w++) begin
          busRead(4*w, 2, rd);
          check("R3 R1 word readback", 64'(rd), 64'(modelWord(w)));
        end
      end
    end

    // idle and busy transfers are ignored
    @(negedge clk);
    hsel = 1; haddr = 32'd0; htrans = 2'b00; hwrite = 1; hsize = 3'd2;
    @(negedge clk);
    hwdata = 32'hDEAD_BEEF; htrans = 2'b01; haddr = 32'd4;
    @(negedge clk);
    idleBus(); hwdata = 32'hCAFE_F00D;
    @(negedge clk);
    check("R4 idle/busy ignored", fieldQ, modelFlat());

    // out-of-window accesses
    errAccess(8, 1'b1);
    errAccess(12, 1'b0);
    errAccess(1337, 1'b1);
    errAccess(255, 1'b0);

    // hardware loads on alternating fields
    @(negedge clk);
    hwFieldData = 64'h4444_3333_2222_1111; hwFieldWe = 4'b0101;
    @(negedge clk);
    hwFieldWe = '0;
    model[0] = 16'h1111; model[2] = 16'h3333;
    check("R8 hw load outputs", fieldQ, modelFlat());
    busRead(4, 2, rd);
    check("R8 hw load bus read", 64'(rd), 64'(modelWord(1)));

    // enable low: data ignored
    @(negedge clk);
    hwFieldData = 64'hABCD_EF01_2345_6789;
    @(negedge clk);
    hwFieldData = 64'h1357_9BDF_0246_8ACE;
    @(negedge clk);
    check("R9 enable low ignored", fieldQ, modelFlat());
    busRead(0, 2, rd);
    check("R9 enable low bus read", 64'(rd), 64'(modelWord(0)));

    // collision: hw load on field 2 during bus word write to offset 4
    @(negedge clk);
    hsel = 1; haddr = 32'd4; htrans = 2'b10; hwrite = 1; hsize = 3'd2;
    @(negedge clk);
    idleBus();
    hwdata = 32'h7777_8888;
    hwFieldData = 64'h0000_1234_0000_0000; hwFieldWe = 4'b0100;
    @(negedge clk);
    hwFieldWe = '0;
    model[2] = 16'h1234; model[3] = 16'h7777;
    check("R10 hw beats bus", fieldQ, modelFlat());

    // reset mid-run
    @(negedge clk);
    rstN = 0;
    @(negedge clk);
    rstN = 1;
    for (int k = 0; k < 4; k++) model[k] = '0;
    check("R11 mid-run reset", fieldQ, 64'd0);
    busRead(4, 2, rd);
    check("R11 read after reset", 64'(rd), 64'd0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule